// File: doc/BRIEF.md
# Byte-Accessible 16-bit Timer

This block is a 16-bit up-counting timer that software reaches over a narrow 8-bit register bus. Four byte addresses are decoded: the low count byte, the high count byte, a control byte and an interrupt byte. Count ticks come from either an internal clock enable or an external count enable that has already been synchronised elsewhere. The ticks pass through a divide-by-1/2/4/8 prescaler and advance the counter while the timer is switched on. When the count wraps from all-ones to zero, a sticky flag is raised and, if enabled, drives the interrupt output.

A control bit picks how the high byte is reached. In direct mode the high address reads and writes the live high byte. In buffered mode the high address only touches a holding byte. Reading the low byte snapshots the live high byte into the holding byte, and writing the low byte loads the holding byte into the live high byte. Either way the two halves of the count are read together and written together, with no race against a carry between two byte accesses. Only a low-byte write restarts the prescaler.

Top module: `byte_timer16`

## Requirements
- R1: After a synchronous reset the count, holding byte, prescaler, control byte, interrupt flag, interrupt enable, `irq` and `rdata` are all 0.
- R2: Address 0 is the low count byte, 1 the high count byte, 2 the control byte and 3 the interrupt byte (bit 0 flag, bit 1 enable, other bits read 0). A read strobe in cycle N places the addressed byte on `rdata` after the clock edge ending cycle N, and it holds there until the next read.
- R3: Control byte: bit 0 timer on, bit 1 source select (0 internal `int_tick`, 1 external `ext_tick`), bit 2 synchronisation select (stored and read back), bits 5:4 prescale, bit 7 buffered mode. Bits 6 and 3 read as 0.
- R4: While timer-on is 1, each prescaled tick from the selected source adds one to the count, and 0xFFFF wraps to 0x0000. Ticks from the unselected source, or any tick while timer-on is 0, leave the count unchanged.
- R5: Prescale 00, 01, 10 and 11 advance the count once per 1, 2, 4 and 8 source ticks.
- R6: A low-byte write clears the prescaler. A high-byte write leaves the prescaler untouched.
- R7: With buffered mode off, the high address reads and writes the live high byte directly, and a low-byte write leaves the high byte unchanged.
- R8: With buffered mode on, a low-byte read copies the live high byte into the holding byte in the same cycle, and high-address reads return the holding byte.
- R9: With buffered mode on, a high-address write loads only the holding byte. A low-byte write loads the low byte from the bus and the high byte from the holding byte in the same edge.
- R10: A count write in the same cycle as a tick takes priority, and the tick is dropped.
- R11: The wrap from 0xFFFF sets the sticky flag. `irq` is 1 exactly when the flag and the enable are both 1, and it changes on the same edge as the flag and the enable.
- R12: Writing the interrupt byte loads the flag and the enable from bits 0 and 1. An overflow in the same cycle as a flag clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| int_tick | input | 1 | Internal count enable |
| ext_tick | input | 1 | Already-synchronised external count enable |
| irq | output | 1 | Interrupt request (flag AND enable) |

## Verification
Every effect in this block lands one edge after its stimulus. A write or tick applied in cycle N shows up in the count, flag and `irq` after the edge ending cycle N, and read data for a strobe in cycle N is on `rdata` from that same edge. The bench drives inputs on falling edges. The scoreboard pushes the expected byte when a read strobe is issued and pops it on the falling edge after the edge that registered the strobe. `irq` is compared on the falling edge that follows the triggering tick or write. Counts are checked only through reads taken while no tick is applied, so the value read is the value computed from the requirements.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [1:0] {
    A_LO  = 2'd0,
    A_HI  = 2'd1,
    A_CTL = 2'd2,
    A_INT = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic       buf16;
    logic [1:0] ps;
    logic       sync;
    logic       src;
    logic       on;
  } ctrl_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [PS_W-1:0] ps,
  input  logic            clr,
  output logic            step
);
  localparam int PW = (1 << PS_W) - 1;

  logic [PW-1:0] pcnt;
  logic [PW-1:0] mask;

  always_comb begin
    mask = (PW'(1) << ps) - PW'(1);
    step = tick && ((pcnt & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) pcnt <= '0;
    else if (tick)  pcnt <= pcnt + PW'(1);
  end

  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> pcnt == '0);
  p_advance_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr) |=> pcnt == $past(pcnt) + PW'(1));
  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(pcnt));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                buffered,
  input  logic                step,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic                rd_lo,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [2*BYTE_W-1:0] cnt,
  output logic [BYTE_W-1:0]   hbuf,
  output logic                ovf
);
  localparam int CNT_W = 2 * BYTE_W;

  always_comb ovf = step && !wr_lo && !wr_hi && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      hbuf <= '0;
    end else begin
      if (wr_lo) begin
        cnt[BYTE_W-1:0] <= wdata;
        if (buffered) cnt[CNT_W-1:BYTE_W] <= hbuf;
      end else if (wr_hi) begin
        if (buffered) hbuf <= wdata;
        else          cnt[CNT_W-1:BYTE_W] <= wdata;
      end else if (step) begin
        cnt <= cnt + CNT_W'(1);
      end
      if (rd_lo && buffered) hbuf <= cnt[CNT_W-1:BYTE_W];
    end
  end

  p_inc_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_lo && !wr_hi && cnt != {CNT_W{1'b1}}) |=> cnt == $past(cnt) + CNT_W'(1));
  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    ovf |=> cnt == '0);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!step && !wr_lo && !wr_hi) |=> $stable(cnt));
  p_bufwr_r9: assert property (@(posedge clk) disable iff (rst)
    (buffered && wr_hi) |=> ($stable(cnt) && hbuf == $past(wdata)));
  p_commit_r9: assert property (@(posedge clk) disable iff (rst)
    (buffered && wr_lo) |=> cnt == {$past(hbuf), $past(wdata)});
  p_direct_r7: assert property (@(posedge clk) disable iff (rst)
    (!buffered && wr_hi) |=> (cnt[CNT_W-1:BYTE_W] == $past(wdata)
                              && cnt[BYTE_W-1:0] == $past(cnt[BYTE_W-1:0])));
  p_snap_r8: assert property (@(posedge clk) disable iff (rst)
    (buffered && rd_lo && !wr_hi) |=> hbuf == $past(cnt[CNT_W-1:BYTE_W]));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic ovf,
  input  logic wr,
  input  logic wflag,
  input  logic wen,
  output logic flag,
  output logic en,
  output logic irq
);
  logic flag_d, en_d;

  always_comb begin
    flag_d = ovf ? 1'b1 : (wr ? wflag : flag);
    en_d   = wr ? wen : en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      en   <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_d;
      en   <= en_d;
      irq  <= flag_d && en_d;
    end
  end

  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (flag && !wr) |=> flag);
  p_ovf_wins_r12: assert property (@(posedge clk) disable iff (rst)
    ovf |=> flag);
  p_irq_r11: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && en));
endmodule

// File: rtl/byte_timer16.sv
module byte_timer16 #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int PS_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              int_tick,
  input  logic              ext_tick,
  output logic              irq
);
  import timer_pkg::*;

  localparam int CNT_W = 2 * DATA_W;

  ctrl_t             ctrl;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] hbuf;
  logic              tick, step, ovf, flag, en;
  logic              wr_lo, wr_hi, wr_ctl, wr_int, rd_lo;

  always_comb begin
    wr_lo  = wr_en && addr == ADDR_W'(A_LO);
    wr_hi  = wr_en && addr == ADDR_W'(A_HI);
    wr_ctl = wr_en && addr == ADDR_W'(A_CTL);
    wr_int = wr_en && addr == ADDR_W'(A_INT);
    rd_lo  = rd_en && addr == ADDR_W'(A_LO);
    tick   = ctrl.on && (ctrl.src ? ext_tick : int_tick);
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (wr_ctl) begin
      ctrl.buf16 <= wdata[7];
      ctrl.ps    <= wdata[5:4];
      ctrl.sync  <= wdata[2];
      ctrl.src   <= wdata[1];
      ctrl.on    <= wdata[0];
    end
  end

  tmr_prescale #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst(rst), .tick(tick), .ps(ctrl.ps), .clr(wr_lo), .step(step)
  );

  tmr_count #(.BYTE_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .buffered(ctrl.buf16), .step(step),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_lo(rd_lo), .wdata(wdata),
    .cnt(cnt), .hbuf(hbuf), .ovf(ovf)
  );

  tmr_irq u_irq (
    .clk(clk), .rst(rst), .ovf(ovf), .wr(wr_int), .wflag(wdata[0]),
    .wen(wdata[1]), .flag(flag), .en(en), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        ADDR_W'(A_LO):  rdata <= cnt[DATA_W-1:0];
        ADDR_W'(A_HI):  rdata <= ctrl.buf16 ? hbuf : cnt[CNT_W-1:DATA_W];
        ADDR_W'(A_CTL): rdata <= DATA_W'({ctrl.buf16, 1'b0, ctrl.ps, 1'b0,
                                          ctrl.sync, ctrl.src, ctrl.on});
        default:        rdata <= DATA_W'({en, flag});
      endcase
    end
  end

  p_rdhold_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  p_ctlpad_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(A_CTL)) |=> (rdata[6] == 1'b0 && rdata[3] == 1'b0));
  p_off_r4: assert property (@(posedge clk) disable iff (rst)
    !ctrl.on |-> !step);
endmodule

// File: tb/byte_timer16_tb.sv
module byte_timer16_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, int_tick = 1'b0, ext_tick = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0, fails = 0;
  logic rd_seen = 1'b0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_timer16 u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .int_tick(int_tick), .ext_tick(ext_tick),
    .irq(irq)
  );

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: pops the expected byte one edge after the strobe
  always @(negedge clk) begin
    if (rd_seen && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        fails++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk); addr = a; rd_en = 1'b1;
    it.exp = e; it.tag = tag; sb.push_back(it);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input int n, input bit ext);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); if (ext) ext_tick = 1'b1; else int_tick = 1'b1;
      @(negedge clk); ext_tick = 1'b0; int_tick = 1'b0;
    end
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq=%b expected=%b", tag, irq, e);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run incomplete, expected finish");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    checks++;
    if (rdata !== 8'h00) begin fails++; $display("FAIL R1: rdata=%h expected=00", rdata); end
    rd(2, 8'h00, "R1 ctrl reset");
    rd(0, 8'h00, "R1 low reset");
    rd(1, 8'h00, "R1 high reset");
    rd(3, 8'h00, "R1 int reset");
    // R7 direct access, R2 map
    wr(1, 8'h12); wr(0, 8'h34);
    rd(0, 8'h34, "R2 low read");
    rd(1, 8'h12, "R7 direct high");
    wr(2, 8'h01);
    pulse(3, 1'b0);
    rd(0, 8'h37, "R4 three ticks");
    rd(1, 8'h12, "R7 high unchanged");
    // R5/R6 prescale
    wr(2, 8'h21); wr(0, 8'h00);
    pulse(7, 1'b0);
    rd(0, 8'h01, "R5 div4 seven ticks");
    wr(1, 8'h12);
    pulse(1, 1'b0);
    rd(0, 8'h02, "R6 high write keeps prescaler");
    wr(0, 8'h10);
    pulse(3, 1'b0);
    rd(0, 8'h10, "R6 low write clears prescaler");
    pulse(1, 1'b0);
    rd(0, 8'h11, "R5 div4 fourth tick");
    wr(2, 8'h11); wr(0, 8'h00);
    pulse(5, 1'b0);
    rd(0, 8'h02, "R5 div2");
    wr(2, 8'h31); wr(0, 8'h00);
    pulse(15, 1'b0);
    rd(0, 8'h01, "R5 div8");
    // R8/R9 buffered
    wr(2, 8'h81);
    rd(2, 8'h81, "R3 ctrl buffered readback");
    wr(1, 8'hAB);
    rd(1, 8'hAB, "R9 high write to buffer");
    wr(0, 8'hCD);
    rd(0, 8'hCD, "R9 commit low");
    rd(1, 8'hAB, "R9 commit high");
    wr(1, 8'h12); wr(0, 8'hFF);
    rd(0, 8'hFF, "R8 snapshot low");
    pulse(1, 1'b0);
    rd(1, 8'h12, "R8 high returns snapshot");
    rd(0, 8'h00, "R4 carry low");
    rd(1, 8'h13, "R8 fresh snapshot");
    wr(1, 8'h55);
    rd(0, 8'h00, "R9 live low kept");
    rd(1, 8'h13, "R9 live high not written");
    // R11/R12 overflow and interrupt
    wr(1, 8'hFF); wr(0, 8'hFE); wr(3, 8'h02);
    pulse(1, 1'b0);
    chk_irq(1'b0, "R11 no irq before wrap");
    pulse(1, 1'b0);
    chk_irq(1'b1, "R11 irq on wrap");
    rd(3, 8'h03, "R11 flag set");
    rd(0, 8'h00, "R4 wrap low");
    rd(1, 8'h00, "R4 wrap high");
    wr(3, 8'h02);
    chk_irq(1'b0, "R12 clear flag");
    rd(3, 8'h02, "R12 flag cleared");
    wr(3, 8'h00); wr(1, 8'hFF); wr(0, 8'hFF);
    pulse(1, 1'b0);
    chk_irq(1'b0, "R11 disabled no irq");
    rd(3, 8'h01, "R11 flag sticky while disabled");
    wr(3, 8'h03);
    chk_irq(1'b1, "R11 enable raises irq");
    wr(3, 8'h02);
    wr(1, 8'hFF); wr(0, 8'hFF);
    @(negedge clk); addr = 2'd3; wdata = 8'h02; wr_en = 1'b1; int_tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; int_tick = 1'b0;
    chk_irq(1'b1, "R12 overflow beats clear");
    rd(3, 8'h03, "R12 flag kept");
    // R3/R4 source select and timer on
    wr(2, 8'h03);
    rd(2, 8'h03, "R3 ctrl ext readback");
    wr(0, 8'h20);
    pulse(2, 1'b0);
    rd(0, 8'h20, "R4 internal ignored on ext source");
    pulse(1, 1'b1);
    rd(0, 8'h21, "R4 ext tick counts");
    wr(2, 8'h02);
    pulse(2, 1'b1);
    rd(0, 8'h21, "R4 timer off holds");
    // R10 write beats tick
    wr(2, 8'h01);
    @(negedge clk); addr = 2'd0; wdata = 8'h40; wr_en = 1'b1; int_tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; int_tick = 1'b0;
    rd(0, 8'h40, "R10 write priority");
    // R3 unimplemented bits
    wr(2, 8'hFF);
    rd(2, 8'hB7, "R3 bits 6 and 3 read 0");
    wr(2, 8'h00);
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule